// File: doc/BRIEF.md
# Accumulator ALU with flag update masks

This block is the combinational arithmetic and logic unit of a small accumulator processor. Each operation takes an operation code, two 8-bit operands `a_i` and `b_i`, and the carry from the status register. It returns an 8-bit result, new values for the negative, zero, carry and overflow flags, and a four-bit update mask. The mask tells the status register which of those flags to write.

Subtraction and compare do not have their own subtractor. They feed the complement of the second operand through the add-with-carry path, so carry means "no borrow". Increment and decrement use the same adder with a constant second operand.

The shift and rotate operations act on `a_i`. The bit-test operation changes only flags. Decimal arithmetic, register storage and instruction sequencing are handled outside this block.

Top module: `alu8_core`

## Requirements
- R1: ADC (op code 3) gives result = low 8 bits of a_i + b_i + carry_i and c_o = bit 8 of that sum; the update mask is 4'b1111.
- R2: For ADC and SBC, v_o is set exactly when a signed overflow occurs: both adder inputs have the same sign and the result sign differs from it.
- R3: SBC (op code 4) gives a_i + ~b_i + carry_i, so carry_i = 1 means no borrow in and c_o = 1 means no borrow out; the update mask is 4'b1111.
- R4: CMP (op code 5) gives result = a_i - b_i (mod 256) and c_o = 1 exactly when a_i >= b_i unsigned; the update mask is 4'b1110, so overflow is not written.
- R5: OR, AND, XOR (op codes 0, 1, 2) give the bitwise result of a_i and b_i and update only N and Z (mask 4'b1100), whatever carry_i is.
- R6: INC (op code 6) and DEC (op code 7) give a_i + 1 and a_i - 1 with wrap-around and update only N and Z (mask 4'b1100).
- R7: ASL (op code 8) and LSR (op code 9) shift a_i by one place left or right and fill the vacated bit with 0; c_o is the bit shifted out, and the mask is 4'b1110.
- R8: ROL (op code 10) and ROR (op code 11) shift a_i by one place and fill the vacated bit with carry_i; c_o is the bit shifted out, and the mask is 4'b1110.
- R9: BIT (op code 12) leaves result = a_i and sets z_o when (a_i AND b_i) is zero, n_o = b_i[7] and v_o = b_i[6]; the mask is 4'b1101.
- R10: For every operation other than BIT that writes N and Z, n_o equals result bit 7 and z_o is set exactly when the result is zero.
- R11: The mask upd_o has N at bit 3, Z at bit 2, C at bit 1 and V at bit 0. A flag whose mask bit is 0 reads 0 on its output.
- R12: Op codes 13 to 15 are reserved: result = a_i, the mask is 4'b0000 and all flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand (accumulator side) |
| b_i | input | 8 | Second operand |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 8 | Operation result |
| n_o | output | 1 | Next negative flag |
| z_o | output | 1 | Next zero flag |
| c_o | output | 1 | Next carry flag |
| v_o | output | 1 | Next overflow flag |
| upd_o | output | 4 | Flag update mask {N,Z,C,V} |

## Verification
The adder is tried with operand pairs chosen to separate its cases:
- Pairs that overflow to a negative sum, pairs that wrap to zero with a carry out, and pairs that cross the sign boundary only because of the incoming carry.
- Subtract pairs with and without borrow, one of which overflows. These show whether the complemented operand and the not-borrow carry are wired correctly.

Compare is tried with equal operands and with a smaller first operand, which separates the greater-or-equal carry rule from a strict greater-than rule. A coarse sweep of operand pairs for add and compare is checked against arithmetic computed in the bench.

Shift and rotate patterns put a 1 at the bit that leaves and feed in a carry of 1. This tells zero fill from carry fill and left from right. The bit-test patterns and the reserved codes show that the result stays equal to `a_i` and that each mask bit and its flag follow the requirements.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_OR  = 4'd0,
    OP_AND = 4'd1,
    OP_XOR = 4'd2,
    OP_ADC = 4'd3,
    OP_SBC = 4'd4,
    OP_CMP = 4'd5,
    OP_INC = 4'd6,
    OP_DEC = 4'd7,
    OP_ASL = 4'd8,
    OP_LSR = 4'd9,
    OP_ROL = 4'd10,
    OP_ROR = 4'd11,
    OP_BIT = 4'd12
  } alu_op_e;

  typedef enum logic [2:0] {
    AS_ADD = 3'd0,
    AS_SUB = 3'd1,
    AS_CMP = 3'd2,
    AS_INC = 3'd3,
    AS_DEC = 3'd4
  } addsub_mode_e;

  typedef enum logic [1:0] {
    SH_ASL = 2'd0,
    SH_LSR = 2'd1,
    SH_ROL = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;

  typedef enum logic [1:0] {
    LG_OR  = 2'd0,
    LG_AND = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  addsub_mode_e     mode_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] opb;
  logic             cin;
  logic [WIDTH:0]   wide;

  // Operand and carry selection for the single shared adder
  always_comb begin
    opb = b_i;
    cin = carry_i;
    case (mode_i)
      AS_ADD: begin opb = b_i;            cin = carry_i; end
      AS_SUB: begin opb = ~b_i;           cin = carry_i; end
      AS_CMP: begin opb = ~b_i;           cin = 1'b1;    end
      AS_INC: begin opb = '0;             cin = 1'b1;    end
      AS_DEC: begin opb = {WIDTH{1'b1}};  cin = 1'b0;    end
      default: begin opb = b_i;           cin = carry_i; end
    endcase
  end

  always_comb begin
    wide   = {1'b0, a_i} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};
    sum_o  = wide[MSB:0];
    cout_o = wide[WIDTH];
    ovf_o  = (a_i[MSB] ^ sum_o[MSB]) & (opb[MSB] ^ sum_o[MSB]);
  end

  // Checks against plain arithmetic on the module ports
  always_comb begin
    if (mode_i == AS_ADD) begin
      p_add_sum_r1: assert ({cout_o, sum_o} ==
                            ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i}))
        else $error("add path sum mismatch");
    end
    if (mode_i == AS_SUB) begin
      p_sub_diff_r3: assert (sum_o == WIDTH'(a_i - b_i - {{(WIDTH-1){1'b0}}, ~carry_i}))
        else $error("subtract path difference mismatch");
    end
    if (mode_i == AS_ADD || mode_i == AS_SUB) begin
      p_signed_ovf_r2: assert (ovf_o == ((a_i[MSB] == opb[MSB]) && (sum_o[MSB] != a_i[MSB])))
        else $error("overflow flag mismatch");
    end
  end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  shift_kind_e      kind_i,
  input  logic [WIDTH-1:0] val_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);
  localparam int MSB = WIDTH - 1;

  logic fill;
  logic left;

  always_comb begin
    left = (kind_i == SH_ASL) || (kind_i == SH_ROL);
    fill = ((kind_i == SH_ROL) || (kind_i == SH_ROR)) ? carry_i : 1'b0;
    if (left) begin
      res_o  = {val_i[MSB-1:0], fill};
      cout_o = val_i[MSB];
    end else begin
      res_o  = {fill, val_i[MSB:1]};
      cout_o = val_i[0];
    end
  end

  always_comb begin
    if (kind_i == SH_ASL || kind_i == SH_LSR) begin
      p_zero_fill_r7: assert (((kind_i == SH_ASL) ? res_o[0] : res_o[MSB]) == 1'b0)
        else $error("logical shift did not fill with zero");
    end
    if (kind_i == SH_ROL) begin
      p_rol_wrap_r8: assert (res_o[0] == carry_i && cout_o == val_i[MSB])
        else $error("rotate left carry mismatch");
    end
    if (kind_i == SH_ROR) begin
      p_ror_wrap_r8: assert (res_o[MSB] == carry_i && cout_o == val_i[0])
        else $error("rotate right carry mismatch");
    end
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic_sel_e       sel_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);

  always_comb begin
    case (sel_i)
      LG_OR:   res_o = a_i | b_i;
      LG_AND:  res_o = a_i & b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = a_i & b_i;
    endcase
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             n_o,
  output logic             z_o,
  output logic             c_o,
  output logic             v_o,
  output logic [3:0]       upd_o
);
  localparam int MSB = WIDTH - 1;

  alu_op_e          op;
  addsub_mode_e     as_mode;
  shift_kind_e      sh_kind;
  logic_sel_e       lg_sel;

  logic [WIDTH-1:0] as_sum;
  logic             as_cout;
  logic             as_ovf;
  logic [WIDTH-1:0] sh_res;
  logic             sh_cout;
  logic [WIDTH-1:0] lg_res;

  logic [WIDTH-1:0] res;
  flags_t           raw;
  flags_t           upd;
  logic             is_bit;

  assign op = alu_op_e'(op_i);

  alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
    .mode_i  (as_mode),
    .a_i     (a_i),
    .b_i     (b_i),
    .carry_i (carry_i),
    .sum_o   (as_sum),
    .cout_o  (as_cout),
    .ovf_o   (as_ovf)
  );

  alu8_shift #(.WIDTH(WIDTH)) u_shift (
    .kind_i  (sh_kind),
    .val_i   (a_i),
    .carry_i (carry_i),
    .res_o   (sh_res),
    .cout_o  (sh_cout)
  );

  alu8_logic #(.WIDTH(WIDTH)) u_logic (
    .sel_i (lg_sel),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (lg_res)
  );

  // Decode: sub-unit selects, result mux, carry and overflow sources, mask
  always_comb begin
    as_mode = AS_ADD;
    sh_kind = SH_ASL;
    lg_sel  = LG_AND;
    res     = a_i;
    raw     = '0;
    upd     = '0;
    is_bit  = 1'b0;
    case (op)
      OP_OR:  begin lg_sel = LG_OR;  res = lg_res; upd = 4'b1100; end
      OP_AND: begin lg_sel = LG_AND; res = lg_res; upd = 4'b1100; end
      OP_XOR: begin lg_sel = LG_XOR; res = lg_res; upd = 4'b1100; end
      OP_ADC: begin
        as_mode = AS_ADD; res = as_sum;
        raw.c = as_cout; raw.v = as_ovf; upd = 4'b1111;
      end
      OP_SBC: begin
        as_mode = AS_SUB; res = as_sum;
        raw.c = as_cout; raw.v = as_ovf; upd = 4'b1111;
      end
      OP_CMP: begin
        as_mode = AS_CMP; res = as_sum;
        raw.c = as_cout; upd = 4'b1110;
      end
      OP_INC: begin as_mode = AS_INC; res = as_sum; upd = 4'b1100; end
      OP_DEC: begin as_mode = AS_DEC; res = as_sum; upd = 4'b1100; end
      OP_ASL: begin sh_kind = SH_ASL; res = sh_res; raw.c = sh_cout; upd = 4'b1110; end
      OP_LSR: begin sh_kind = SH_LSR; res = sh_res; raw.c = sh_cout; upd = 4'b1110; end
      OP_ROL: begin sh_kind = SH_ROL; res = sh_res; raw.c = sh_cout; upd = 4'b1110; end
      OP_ROR: begin sh_kind = SH_ROR; res = sh_res; raw.c = sh_cout; upd = 4'b1110; end
      OP_BIT: begin
        lg_sel = LG_AND; is_bit = 1'b1; res = a_i;
        raw.n = b_i[MSB]; raw.v = b_i[MSB-1]; raw.z = ~|lg_res;
        upd = 4'b1101;
      end
      default: begin res = a_i; upd = '0; end
    endcase
    if (!is_bit) begin
      raw.n = res[MSB];
      raw.z = ~|res;
    end
  end

  // Flags not written by the selected operation read zero
  always_comb begin
    result_o = res;
    upd_o    = upd;
    n_o      = raw.n & upd.n;
    z_o      = raw.z & upd.z;
    c_o      = raw.c & upd.c;
    v_o      = raw.v & upd.v;
  end

  always_comb begin
    if (op_i == 4'd5) begin
      p_cmp_carry_r4: assert (c_o == (a_i >= b_i) && upd_o[0] == 1'b0)
        else $error("compare carry or mask mismatch");
    end
    if (op_i <= 4'd2) begin
      p_logic_keeps_cv_r5: assert (upd_o[1:0] == 2'b00)
        else $error("logic op wrote carry or overflow");
    end
    if (op_i == 4'd12) begin
      p_bit_keeps_a_r9: assert (result_o == a_i && n_o == b_i[MSB] && v_o == b_i[MSB-1])
        else $error("bit test result or flags mismatch");
    end
    if (op_i >= 4'd13) begin
      p_reserved_quiet_r12: assert (upd_o == 4'b0000 && result_o == a_i)
        else $error("reserved op not inert");
    end
  end

endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb;

  logic       clk;
  logic       rst_n;
  logic [3:0] op;
  logic [7:0] a;
  logic [7:0] b;
  logic       cin;
  logic [7:0] res;
  logic       n, z, c, v;
  logic [3:0] upd;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  alu8_core u_dut (
    .op_i     (op),
    .a_i      (a),
    .b_i      (b),
    .carry_i  (cin),
    .result_o (res),
    .n_o      (n),
    .z_o      (z),
    .c_o      (c),
    .v_o      (v),
    .upd_o    (upd)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {req, op, a, b, cin, exp_result, exp_flags NZCV, exp_mask NZCV}
  localparam int NV = 23;
  localparam logic [40:0] VEC [NV] = '{
    {4'd1,  4'd3,  8'h50, 8'h50, 1'b0, 8'hA0, 4'b1001, 4'b1111}, // R1 R2 overflow
    {4'd1,  4'd3,  8'hFF, 8'h01, 1'b0, 8'h00, 4'b0110, 4'b1111}, // R1 wrap to zero
    {4'd2,  4'd3,  8'h7F, 8'h00, 1'b1, 8'h80, 4'b1001, 4'b1111}, // R2 carry-in overflow
    {4'd3,  4'd4,  8'h50, 8'hF0, 1'b1, 8'h60, 4'b0000, 4'b1111}, // R3 borrow out
    {4'd2,  4'd4,  8'h50, 8'hB0, 1'b1, 8'hA0, 4'b1001, 4'b1111}, // R2 sub overflow
    {4'd3,  4'd4,  8'h05, 8'h03, 1'b0, 8'h01, 4'b0010, 4'b1111}, // R3 borrow in
    {4'd4,  4'd5,  8'h40, 8'h40, 1'b0, 8'h00, 4'b0110, 4'b1110}, // R4 equal
    {4'd4,  4'd5,  8'h10, 8'h20, 1'b1, 8'hF0, 4'b1000, 4'b1110}, // R4 less
    {4'd5,  4'd0,  8'h0F, 8'hF0, 1'b1, 8'hFF, 4'b1000, 4'b1100}, // R5 OR
    {4'd5,  4'd1,  8'h0F, 8'hF0, 1'b1, 8'h00, 4'b0100, 4'b1100}, // R5 AND
    {4'd5,  4'd2,  8'hAA, 8'h2A, 1'b0, 8'h80, 4'b1000, 4'b1100}, // R5 XOR
    {4'd6,  4'd6,  8'hFF, 8'h00, 1'b1, 8'h00, 4'b0100, 4'b1100}, // R6 INC wrap
    {4'd6,  4'd7,  8'h00, 8'h00, 1'b0, 8'hFF, 4'b1000, 4'b1100}, // R6 DEC wrap
    {4'd6,  4'd7,  8'h01, 8'h00, 1'b1, 8'h00, 4'b0100, 4'b1100}, // R6 DEC to zero
    {4'd7,  4'd8,  8'h81, 8'h00, 1'b1, 8'h02, 4'b0010, 4'b1110}, // R7 ASL
    {4'd7,  4'd9,  8'h01, 8'h00, 1'b1, 8'h00, 4'b0110, 4'b1110}, // R7 LSR
    {4'd8,  4'd10, 8'h40, 8'h00, 1'b1, 8'h81, 4'b1000, 4'b1110}, // R8 ROL
    {4'd8,  4'd11, 8'h01, 8'h00, 1'b1, 8'h80, 4'b1010, 4'b1110}, // R8 ROR carry in
    {4'd8,  4'd11, 8'h02, 8'h00, 1'b0, 8'h01, 4'b0000, 4'b1110}, // R8 ROR zero in
    {4'd9,  4'd12, 8'h0F, 8'hC0, 1'b0, 8'h0F, 4'b1101, 4'b1101}, // R9 disjoint
    {4'd9,  4'd12, 8'h41, 8'h01, 1'b1, 8'h41, 4'b0000, 4'b1101}, // R9 overlap
    {4'd12, 4'd13, 8'h37, 8'h55, 1'b1, 8'h37, 4'b0000, 4'b0000}, // R12
    {4'd12, 4'd15, 8'h00, 8'h00, 1'b1, 8'h00, 4'b0000, 4'b0000}  // R12 R11 zero hidden
  };

  task automatic apply(input logic [3:0] o, input logic [7:0] x,
                       input logic [7:0] y, input logic ci);
    @(negedge clk);
    op = o; a = x; b = y; cin = ci;
    #5;
  endtask

  task automatic check(input int req, input logic [7:0] er,
                       input logic [3:0] ef, input logic [3:0] eu);
    checks++;
    if (res !== er || {n, z, c, v} !== ef || upd !== eu) begin
      fails++;
      $display("FAIL R%0d op=%0d a=%h b=%h cin=%b: got res=%h flags=%b upd=%b exp res=%h flags=%b upd=%b",
               req, op, a, b, cin, res, {n, z, c, v}, upd, er, ef, eu);
    end
  endtask

  initial begin
    op = '0; a = '0; b = '0; cin = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Quiet state after reset: OR of zeros, R10 zero flag and R11 mask
    apply(4'd0, 8'h00, 8'h00, 1'b0);
    check(10, 8'h00, 4'b0100, 4'b1100);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][36:33], VEC[i][32:25], VEC[i][24:17], VEC[i][16]);
      check(int'(VEC[i][40:37]), VEC[i][15:8], VEC[i][7:4], VEC[i][3:0]);
    end

    // Sweep for R1 and R4 against bench arithmetic, R10 for N and Z
    for (int i = 0; i < 256; i += 37) begin
      for (int j = 0; j < 256; j += 53) begin
        logic [8:0] s;
        logic [7:0] d;
        logic       ov;
        s  = 9'(i) + 9'(j) + 9'(i & 1);
        ov = (i[7] == j[7]) && (s[7] != i[7]);
        apply(4'd3, 8'(i), 8'(j), i[0]);
        check(1, s[7:0], {s[7], s[7:0] == 8'h00, s[8], ov}, 4'b1111);
        d = 8'(i - j);
        apply(4'd5, 8'(i), 8'(j), 1'b0);
        check(4, d, {d[7], d == 8'h00, i >= j, 1'b0}, 4'b1110);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule